// File: doc/BRIEF.md
# Segment Line Loader with Cascade Enable

This block takes one line of column pixel data from a controller over a narrow parallel bus. Several identical chips can share the bus. A line pulse arms the chip. The chip then waits for its enable input to go low, which means the chip before it in the chain has finished. While it is selected, each falling edge of the data clock delivers either a full byte (wide mode) or one nibble (narrow mode, two nibbles per byte).

Each byte is steered into a data latch. The fill order depends on a direction input, and the write pointer moves one 16-pixel group every two bytes. When the chip has taken its full count of pixels, it deselects itself, ignores any further data clocks, and pulls its enable output low to hand the bus to the next chip. On the falling edge of the next line pulse, the data latch is copied into the line latch. The line latch drives a 2-bit level code per output, which also depends on a frame-inversion input.

All logic runs on one system clock. The data clock and the line pulse are synchronized, and their falling edges are detected internally.

Top module: `seg_line_loader`

## Requirements
- R1: With `wide_i` high, each accepted data clock takes `dat_i[7:0]` as one byte. With `wide_i` low, two data clocks form one byte: the first nibble becomes byte bits 3:0 and the second becomes bits 7:4, both taken from `dat_i[3:0]`. In that mode `dat_i[7:4]` has no effect.
- R2: Data is taken only on falling edges of `xck_i`.
- R3: A falling edge of `lp_i` copies the data latch into the line latch and restarts the pixel count and the fill pointer. After reset the line latch is zero.
- R4: After a line pulse the chip becomes selected once its enable input is low. Data clocks that arrive before selection, or after `PIXELS` pixels have been taken, are ignored.
- R5: The enable output is high after reset and after each line pulse. It goes low once `PIXELS` pixels have been loaded.
- R6: With `dir_i` high, bit b of byte k goes to pixel 8k+b, `en_a_i` is the enable input and `en_b_o` is the enable output. With `dir_i` low, bit b of byte k goes to pixel PIXELS-1-(8k+b), `en_b_i` is the input and `en_a_o` is the output. The enable output that is not in use stays high.
- R7: The data latch is written in 16-pixel groups. A line that stops early leaves the pixels it did not reach unchanged, and those old values reach the line latch on the next line pulse.
- R8: While `blank_ni` is low, the line latch is cleared and every output code is 00. The data latch still loads, and the cleared line latch stays zero after `blank_ni` rises, until the next line pulse.
- R9: The output code for pixel i is `drv_o[2i+1:2i]` = {`frm_i` XOR pix, pix}, where pix is line latch bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xck_i | input | 1 | Data clock; data taken on its falling edge |
| lp_i | input | 1 | Line pulse; its falling edge transfers the line |
| dat_i | input | 8 | Parallel pixel data bus |
| wide_i | input | 1 | 1: 8-bit bus, 0: 4-bit bus |
| dir_i | input | 1 | Fill order and enable pin roles |
| en_a_i | input | 1 | Enable input at end A (active low) |
| en_b_i | input | 1 | Enable input at end B (active low) |
| en_a_o | output | 1 | Enable output at end A (active low) |
| en_b_o | output | 1 | Enable output at end B (active low) |
| blank_ni | input | 1 | Display off, active low |
| frm_i | input | 1 | Frame inversion |
| drv_o | output | 2*PIXELS | Two-bit level code per pixel |

## Verification
Random lines are loaded in both bus widths and both directions. In narrow mode the upper bus bits carry random garbage, so a swapped nibble order, a mirrored fill or a leak from the upper bits shows up as a pixel mismatch. Directed cases cover these situations: data clocks before selection and after the last pixel, a line cut off after one group (which exposes the old latch contents), and loading while the display is off. The enable output is checked one byte before the end of a line and again at the end, which separates an early token from a late one. Each line is shown with both frame-inversion values, so both bits of the code are checked.

// File: rtl/seg_cap_pkg.sv
package seg_cap_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEL   = 2'd2,
    ST_DONE  = 2'd3
  } cap_st_e;
endpackage

// File: rtl/seg_edge_sync.sv
module seg_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= 1'b0;
      else if (s == 0) chain_q[s] <= sig_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= chain_q[STAGES-1];
  end

  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/seg_nib_packer.sv
module seg_nib_packer
  import seg_cap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              stb_i,
  input  logic              wide_i,
  input  logic [BYTE_W-1:0] dat_i,
  output logic              vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic       phase_q;
  logic [3:0] nib_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      nib_q   <= '0;
    end else if (clr_i) begin
      phase_q <= 1'b0;
    end else if (stb_i && !wide_i) begin
      phase_q <= ~phase_q;
      if (!phase_q) nib_q <= dat_i[3:0];
    end
  end

  always_comb begin
    if (wide_i) begin
      vld_o  = stb_i;
      byte_o = dat_i;
    end else begin
      vld_o  = stb_i & phase_q;
      byte_o = {dat_i[3:0], nib_q};
    end
  end

  AST_NIB_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && stb_i && !clr_i) |=> (phase_q != $past(phase_q))); // R1
endmodule

// File: rtl/seg_data_latch.sv
module seg_data_latch
  import seg_cap_pkg::*;
#(
  parameter int unsigned PIXELS  = 160,
  parameter int unsigned GROUP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic              dir_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [PIXELS-1:0] dl_o
);
  localparam int unsigned GROUPS = PIXELS / GROUP_W;
  localparam int unsigned HALVES = GROUP_W / BYTE_W;
  localparam int unsigned PTR_W  = $clog2(GROUPS + 1);
  localparam int unsigned SUB_W  = (HALVES > 1) ? $clog2(HALVES) : 1;

  logic [PTR_W-1:0]  ptr_q;
  logic [SUB_W-1:0]  sub_q;
  logic [PIXELS-1:0] dl_q;
  logic [BYTE_W-1:0] rev;

  always_comb
    for (int b = 0; b < BYTE_W; b++) rev[b] = byte_i[BYTE_W-1-b];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      sub_q <= '0;
    end else if (clr_i) begin
      ptr_q <= '0;
      sub_q <= '0;
    end else if (we_i) begin
      if (sub_q == SUB_W'(HALVES-1)) begin
        sub_q <= '0;
        ptr_q <= ptr_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  // forward fill: slot (ptr,sub); reverse fill: mirrored slot with mirrored bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dl_q <= '0;
    else if (we_i) begin
      for (int g = 0; g < GROUPS; g++)
        for (int s = 0; s < HALVES; s++) begin
          if (dir_i && ptr_q == PTR_W'(g) && sub_q == SUB_W'(s))
            dl_q[g*GROUP_W + s*BYTE_W +: BYTE_W] <= byte_i;
          else if (!dir_i && ptr_q == PTR_W'(GROUPS-1-g) && sub_q == SUB_W'(HALVES-1-s))
            dl_q[g*GROUP_W + s*BYTE_W +: BYTE_W] <= rev;
        end
    end
  end

  assign dl_o = dl_q;

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (ptr_q == $past(ptr_q) || ptr_q == $past(ptr_q) + 1'b1)); // R7
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PTR_W'(GROUPS)); // R7
endmodule

// File: rtl/seg_line_loader.sv
module seg_line_loader
  import seg_cap_pkg::*;
#(
  parameter int unsigned PIXELS  = 160,
  parameter int unsigned GROUP_W = 16,
  parameter int unsigned STAGES  = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  xck_i,
  input  logic                  lp_i,
  input  logic [BYTE_W-1:0]     dat_i,
  input  logic                  wide_i,
  input  logic                  dir_i,
  input  logic                  en_a_i,
  input  logic                  en_b_i,
  output logic                  en_a_o,
  output logic                  en_b_o,
  input  logic                  blank_ni,
  input  logic                  frm_i,
  output logic [2*PIXELS-1:0]   drv_o
);
  localparam int unsigned CNT_W = $clog2(PIXELS + 1);

  logic xck_fall, lp_fall;
  logic [BYTE_W-1:0] dat_pipe [STAGES];
  logic byte_vld;
  logic [BYTE_W-1:0] byte_val;
  logic [PIXELS-1:0] dl, line_q;
  cap_st_e st_q;
  logic [CNT_W-1:0] cnt_q;
  logic en_in, tok_n, sel, dl_we;

  seg_edge_sync #(.STAGES(STAGES)) i_xck_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(xck_i), .fall_o(xck_fall));
  seg_edge_sync #(.STAGES(STAGES)) i_lp_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(lp_i), .fall_o(lp_fall));

  // data delayed to line up with the synchronized clock edge
  for (genvar s = 0; s < STAGES; s++) begin : g_dpipe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dat_pipe[s] <= '0;
      else if (s == 0) dat_pipe[s] <= dat_i;
      else dat_pipe[s] <= dat_pipe[(s == 0) ? 0 : s-1];
    end
  end

  assign sel = (st_q == ST_SEL);

  seg_nib_packer i_packer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(lp_fall),
    .stb_i(xck_fall & sel & ~lp_fall), .wide_i(wide_i),
    .dat_i(dat_pipe[STAGES-1]), .vld_o(byte_vld), .byte_o(byte_val));

  assign dl_we = byte_vld;

  seg_data_latch #(.PIXELS(PIXELS), .GROUP_W(GROUP_W)) i_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(lp_fall), .we_i(dl_we),
    .dir_i(dir_i), .byte_i(byte_val), .dl_o(dl));

  assign en_in = dir_i ? en_a_i : en_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (lp_fall) begin
      st_q  <= ST_ARMED;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_ARMED: if (!en_in) st_q <= ST_SEL;
        ST_SEL: if (dl_we) begin
          cnt_q <= cnt_q + CNT_W'(BYTE_W);
          if (cnt_q == CNT_W'(PIXELS - BYTE_W)) st_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  assign tok_n  = (st_q != ST_DONE);
  assign en_a_o = dir_i ? 1'b1 : tok_n;
  assign en_b_o = dir_i ? tok_n : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else if (!blank_ni) line_q <= '0;
    else if (lp_fall) line_q <= dl;
  end

  always_comb
    for (int i = 0; i < PIXELS; i++)
      drv_o[2*i +: 2] = blank_ni ? {frm_i ^ line_q[i], line_q[i]} : 2'b00;

  AST_SEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel |-> cnt_q < CNT_W'(PIXELS)); // R4
  AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel && !lp_fall) |=> $stable(cnt_q)); // R4
  AST_TOKEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tok_n) |-> cnt_q == CNT_W'(PIXELS)); // R5
  AST_BLANK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |=> line_q == '0); // R8
endmodule

// File: tb/test_seg_line_loader.sv
module test_seg_line_loader;
  localparam int unsigned PIXELS = 160;
  localparam int unsigned NBYTES = PIXELS / 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic xck = 1'b1, lp = 1'b0, wide = 1'b1, dir = 1'b1;
  logic en_a = 1'b1, en_b = 1'b1, blank_n = 1'b1, frm = 1'b0;
  logic [7:0] dat = '0;
  logic en_a_o, en_b_o;
  logic [2*PIXELS-1:0] drv;

  int checks = 0, errors = 0;
  logic [PIXELS-1:0] m_dl = '0, m_line = '0;
  int m_cnt = 0;
  bit m_sel = 0, m_arm = 0, done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_line_loader i_seg_line_loader (
    .clk_i(clk), .rst_ni(rst_ni), .xck_i(xck), .lp_i(lp), .dat_i(dat),
    .wide_i(wide), .dir_i(dir), .en_a_i(en_a), .en_b_i(en_b),
    .en_a_o(en_a_o), .en_b_o(en_b_o), .blank_ni(blank_n), .frm_i(frm),
    .drv_o(drv));

  function automatic logic [2*PIXELS-1:0] exp_drv(logic [PIXELS-1:0] ln, logic f, logic bn);
    logic [2*PIXELS-1:0] e;
    for (int i = 0; i < PIXELS; i++) e[2*i +: 2] = bn ? {f ^ ln[i], ln[i]} : 2'b00;
    return e;
  endfunction

  task automatic chk_drv(string tag);
    logic [2*PIXELS-1:0] e;
    e = exp_drv(m_line, frm, blank_n);
    checks++;
    if (drv !== e) begin
      errors++;
      $display("FAIL %s drv act=%h exp=%h", tag, drv, e);
    end
  endtask

  task automatic chk_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_xck();
    xck = 1'b0; wait_clk(4);
    xck = 1'b1; wait_clk(4);
  endtask

  task automatic model_byte(logic [7:0] b);
    if (!m_sel) return;
    for (int k = 0; k < 8; k++) begin
      int p;
      p = m_cnt + k;
      if (dir) m_dl[p] = b[k];
      else m_dl[PIXELS-1-p] = b[k];
    end
    m_cnt += 8;
    if (m_cnt == PIXELS) m_sel = 0;
  endtask

  task automatic send_byte(logic [7:0] b);
    if (wide) begin
      dat = b; pulse_xck();
    end else begin
      dat = {4'($urandom), b[3:0]}; pulse_xck();
      dat = {4'($urandom), b[7:4]}; pulse_xck();
    end
    model_byte(b);
  endtask

  task automatic line_pulse();
    lp = 1'b1; wait_clk(4);
    lp = 1'b0; wait_clk(4);
    m_line = blank_n ? m_dl : '0;
    m_cnt = 0; m_sel = 0; m_arm = 1;
  endtask

  task automatic select_chip();
    en_a = dir ? 1'b0 : 1'b1;
    en_b = dir ? 1'b1 : 1'b0;
    wait_clk(4);
    if (m_arm) begin m_sel = 1; m_arm = 0; end
  endtask

  task automatic release_en();
    en_a = 1'b1; en_b = 1'b1;
  endtask

  task automatic load_bytes(int n);
    for (int i = 0; i < n; i++) send_byte(8'($urandom));
  endtask

  function automatic logic tok_out();
    return dir ? en_b_o : en_a_o;
  endfunction
  function automatic logic idle_out();
    return dir ? en_a_o : en_b_o;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(2);
    chk_drv("R3 reset line latch zero");
    chk_bit("R5 reset en_a_o high", en_a_o, 1'b1);
    chk_bit("R5 reset en_b_o high", en_b_o, 1'b1);

    // forward fill, 8-bit bus
    dir = 1'b1; wide = 1'b1;
    line_pulse();
    select_chip();
    load_bytes(NBYTES - 1);
    chk_bit("R5 token high before last byte", tok_out(), 1'b1);
    load_bytes(1);
    chk_bit("R5 token low after full line", tok_out(), 1'b0);
    chk_bit("R6 unused end stays high", idle_out(), 1'b1);
    load_bytes(2); // ignored after full count (R4)
    release_en();
    line_pulse();
    chk_bit("R5 token high after line pulse", tok_out(), 1'b1);
    frm = 1'b0; chk_drv("R1 R6 R3 R4 forward wide line");
    frm = 1'b1; wait_clk(1); chk_drv("R9 frame inverted codes");

    // reverse fill, 4-bit bus, clocks before selection ignored
    dir = 1'b0; wide = 1'b0; frm = 1'b0;
    line_pulse();
    load_bytes(2); // not selected yet (R4)
    select_chip();
    load_bytes(NBYTES);
    chk_bit("R6 reverse token on end A", en_a_o, 1'b0);
    chk_bit("R6 reverse end B stays high", en_b_o, 1'b1);
    release_en();
    line_pulse();
    chk_drv("R1 R2 R4 R6 reverse narrow line");
    frm = 1'b1; wait_clk(1); chk_drv("R9 reverse narrow inverted");

    // data clock held high while data changes: no sample (R2)
    dir = 1'b1; wide = 1'b1; frm = 1'b0;
    select_chip();
    dat = 8'hA5; wait_clk(6);
    dat = 8'h3C; wait_clk(6);
    load_bytes(2); // partial line, one group (R7)
    release_en();
    line_pulse();
    chk_drv("R2 R7 partial line keeps old pixels");

    // display off while loading
    select_chip();
    blank_n = 1'b0; m_line = '0; wait_clk(1);
    chk_drv("R8 blank forces 00");
    load_bytes(NBYTES);
    release_en();
    line_pulse();
    chk_drv("R8 line pulse while blank");
    blank_n = 1'b1; wait_clk(2);
    chk_drv("R8 line stays clear after blank release");
    line_pulse();
    chk_drv("R8 data latch loaded during blank");

    // random lines
    for (int r = 0; r < 4; r++) begin
      dir = 1'($urandom); wide = 1'($urandom); frm = 1'b0;
      select_chip();
      load_bytes(NBYTES);
      chk_bit("R5 random token low", tok_out(), 1'b0);
      release_en();
      line_pulse();
      chk_drv("R1 R6 random line");
      frm = 1'b1; wait_clk(1); chk_drv("R9 random line inverted");
    end

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule